// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block decides, for every received HDLC frame, whether the frame is addressed to this station. The receive path hands it the address octets one at a time with a strobe, framed by a start pulse and an end pulse. The block checks them against four programmable address registers and fixed group addresses, then reports accept or reject once per frame.

Each address octet goes through a comparator with two settings. In list mode, the octet passes when it equals either of its two registers or the group address. In mask mode, the second register becomes a don't-care mask for the first, and the group address still passes. The byte-count select chooses the frame format. With one octet, only the low comparator is used. With two octets, the first octet goes to the high comparator and the second to the low comparator, and both must pass.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset all four address registers read 00 hex and `res_vld` is low.
- R2: A write with `cfg_we` high stores `cfg_wdata` at the next clock edge, and `cfg_rdata` shows the register selected by `cfg_addr` combinationally and unchanged. The selections are 0 = high primary, 1 = high secondary, 2 = low primary and 3 = low secondary.
- R3: In list mode (mode bit 0), an octet passes when it equals the primary register, the secondary register or the group address.
- R4: In mask mode (mode bit 1), an octet passes when it equals the primary register at every bit where the secondary register holds 0, or when it equals the group address.
- R5: The high group address is FC hex with bit 1 ignored, so FC and FE both pass and FD does not. The low group address is FF hex.
- R6: With `two_byte` at 0, the single address octet is judged by the low comparator alone, and the high registers have no effect.
- R7: With `two_byte` at 1, the first octet is judged by the high comparator and the second by the low comparator. The frame is accepted only when both pass.
- R8: `res_vld` pulses for one cycle in the cycle after the strobe of the final address octet. `res_accept` is updated in that same cycle and then holds.
- R9: If `rx_end` arrives while the frame still lacks address octets, `res_vld` pulses in the next cycle with `res_accept` at 0.
- R10: Octet strobes and `rx_end` seen before the first `rx_start`, or after a frame's result, produce no result until the next `rx_start`.
- R11: A register write in the same cycle as an octet strobe takes effect after that octet has been compared, so the octet is judged against the old value.
- R12: Inputs in one cycle are applied in this order: `rx_start` first, then the octet strobe, then `rx_end`. An `rx_end` that comes with the final octet therefore yields a normal judgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the selected register |
| mask_hi | input | 1 | High comparator mode: 0 list, 1 mask |
| mask_lo | input | 1 | Low comparator mode: 0 list, 1 mask |
| two_byte | input | 1 | Address field length: 0 one octet, 1 two octets |
| rx_start | input | 1 | Frame start pulse |
| rx_byte_vld | input | 1 | Address octet strobe |
| rx_byte | input | 8 | Address octet |
| rx_end | input | 1 | Frame end pulse |
| res_vld | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Frame accepted (valid with res_vld, then held) |

## Verification
The collisions that matter here are a register write landing in the same cycle as the octet that reads that register, and a frame end landing in the same cycle as the last address octet or as a frame start. The bench drives each pair together on purpose. A behavioural model applies the stated ordering and compares result, accept flag and read-back on every clock. Under that ordering, the old register value decides the octet, an end with the final octet still gives a real verdict, and an end with the first of two octets gives a reject.

// File: rtl/haf_pkg.sv
package haf_pkg;
  localparam int unsigned OCTET_W = 8;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned SEL_W = $clog2(NUM_REGS);

  typedef logic [OCTET_W-1:0] octet_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_HI_PRI = 2'd0,
    SEL_HI_SEC = 2'd1,
    SEL_LO_PRI = 2'd2,
    SEL_LO_SEC = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/haf_regbank.sv
module haf_regbank
  import haf_pkg::*;
#(
  parameter int unsigned W = OCTET_W,
  parameter int unsigned N = NUM_REGS,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  regs_o [N]
);
  logic [W-1:0] regs_q [N];
  logic [W-1:0] regs_d [N];
  logic [N-1:0] reg_en;

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_comb begin
      reg_en[g] = we && (addr == AW'(g));
      regs_d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (reg_en[g]) begin
        regs_q[g] <= regs_d[g];
      end
    end

    assign regs_o[g] = regs_q[g];
  end

  assign rdata = regs_q[addr];

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && addr == $past(addr)) |-> rdata == $past(wdata));
endmodule

// File: rtl/haf_octet_match.sv
module haf_octet_match
  import haf_pkg::*;
#(
  parameter int unsigned W = OCTET_W,
  parameter logic [W-1:0] GROUP = '1,
  parameter logic [W-1:0] GROUP_DC = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_mode,
  input  logic [W-1:0] octet,
  input  logic [W-1:0] ref_pri,
  input  logic [W-1:0] ref_sec,
  output logic         hit
);
  logic grp_hit;
  logic pri_hit;
  logic sec_hit;
  logic [W-1:0] care;

  always_comb begin
    grp_hit = ((octet ^ GROUP) & ~GROUP_DC) == '0;
    care    = mask_mode ? ~ref_sec : '1;
    pri_hit = ((octet ^ ref_pri) & care) == '0;
    sec_hit = !mask_mode && (octet == ref_sec);
    hit     = grp_hit || pri_hit || sec_hit;
  end

  // R3
  list_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_mode && (octet == ref_pri || octet == ref_sec)) |-> hit);

  // R4
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_mode && ref_sec == '1) |-> hit);
endmodule

// File: rtl/haf_frame_seq.sv
module haf_frame_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_start,
  input  logic rx_byte_vld,
  input  logic rx_end,
  input  logic two_byte,
  input  logic hi_hit,
  input  logic lo_hit,
  output logic res_vld,
  output logic res_accept
);
  logic act_q, act_d;
  logic got_hi_q, got_hi_d;
  logic hi_ok_q, hi_ok_d;
  logic vld_q, vld_d;
  logic acc_q, acc_d;
  logic live;

  always_comb begin
    act_d    = act_q;
    got_hi_d = got_hi_q;
    hi_ok_d  = hi_ok_q;
    vld_d    = 1'b0;
    acc_d    = acc_q;
    if (rx_start) begin
      act_d    = 1'b1;
      got_hi_d = 1'b0;
      hi_ok_d  = 1'b0;
    end
    live = act_d;
    if (live && rx_byte_vld) begin
      if (two_byte && !got_hi_d) begin
        got_hi_d = 1'b1;
        hi_ok_d  = hi_hit;
      end else begin
        vld_d = 1'b1;
        acc_d = two_byte ? (hi_ok_d && lo_hit) : lo_hit;
        act_d = 1'b0;
      end
    end
    if (act_d && rx_end) begin
      vld_d = 1'b1;
      acc_d = 1'b0;
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      got_hi_q <= 1'b0;
      hi_ok_q  <= 1'b0;
      vld_q    <= 1'b0;
      acc_q    <= 1'b0;
    end else begin
      act_q    <= act_d;
      got_hi_q <= got_hi_d;
      hi_ok_q  <= hi_ok_d;
      vld_q    <= vld_d;
      acc_q    <= acc_d;
    end
  end

  assign res_vld    = vld_q;
  assign res_accept = acc_q;

  // R9
  early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && rx_end && !rx_start && !rx_byte_vld) |=> (res_vld && !res_accept));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !rx_start) |=> !res_vld);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> !act_q);

  // R8
  accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> $stable(res_accept));
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import haf_pkg::*;
#(
  parameter int unsigned W = OCTET_W,
  parameter logic [W-1:0] HI_GROUP = 8'hFC,
  parameter logic [W-1:0] HI_GROUP_DC = 8'h02,
  parameter logic [W-1:0] LO_GROUP = 8'hFF,
  parameter logic [W-1:0] LO_GROUP_DC = 8'h00,
  localparam int unsigned N = NUM_REGS,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [W-1:0]  cfg_wdata,
  output logic [W-1:0]  cfg_rdata,
  input  logic          mask_hi,
  input  logic          mask_lo,
  input  logic          two_byte,
  input  logic          rx_start,
  input  logic          rx_byte_vld,
  input  logic [W-1:0]  rx_byte,
  input  logic          rx_end,
  output logic          res_vld,
  output logic          res_accept
);
  logic [W-1:0] regs [N];
  logic [1:0]   hits;
  logic [1:0]   modes;

  assign modes = {mask_lo, mask_hi};

  haf_regbank #(.W(W), .N(N)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .regs_o(regs)
  );

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    localparam logic [W-1:0] GRP = (g == 0) ? HI_GROUP : LO_GROUP;
    localparam logic [W-1:0] GDC = (g == 0) ? HI_GROUP_DC : LO_GROUP_DC;
    haf_octet_match #(.W(W), .GROUP(GRP), .GROUP_DC(GDC)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_mode(modes[g]),
      .octet    (rx_byte),
      .ref_pri  (regs[2*g]),
      .ref_sec  (regs[2*g+1]),
      .hit      (hits[g])
    );
  end

  haf_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_start   (rx_start),
    .rx_byte_vld(rx_byte_vld),
    .rx_end     (rx_end),
    .two_byte   (two_byte),
    .hi_hit     (hits[0]),
    .lo_hit     (hits[1]),
    .res_vld    (res_vld),
    .res_accept (res_accept)
  );
endmodule

// File: tb/hdlc_addr_filter_tb.sv
module hdlc_addr_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic mask_hi = 1'b0, mask_lo = 1'b0, two_byte = 1'b0;
  logic rx_start = 1'b0, rx_byte_vld = 1'b0, rx_end = 1'b0;
  logic [7:0] rx_byte = '0;
  logic res_vld, res_accept;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";

  logic [7:0] m_regs [4];
  bit m_act = 0, m_got = 0, m_hiok = 0, m_vld = 0, m_acc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mask_hi(mask_hi),
    .mask_lo(mask_lo), .two_byte(two_byte), .rx_start(rx_start),
    .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .rx_end(rx_end),
    .res_vld(res_vld), .res_accept(res_accept)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit passes(logic [7:0] b, logic [7:0] p, logic [7:0] s, bit msk, bit hi);
    if (hi && (b == 8'hFC || b == 8'hFE)) return 1;
    if (!hi && b == 8'hFF) return 1;
    if (!msk) return (b == p) || (b == s);
    for (int i = 0; i < 8; i++)
      if (!s[i] && (b[i] != p[i])) return 0;
    return 1;
  endfunction

  task automatic tick();
    bit na, ng, nh, nv, nacc;
    na = m_act; ng = m_got; nh = m_hiok; nv = 0; nacc = m_acc;
    if (rx_start) begin na = 1; ng = 0; nh = 0; end
    if (na && rx_byte_vld) begin
      if (two_byte && !ng) begin
        ng = 1;
        nh = passes(rx_byte, m_regs[0], m_regs[1], mask_hi, 1);
      end else begin
        nv = 1; na = 0;
        nacc = passes(rx_byte, m_regs[2], m_regs[3], mask_lo, 0);
        if (two_byte) nacc = nacc && nh;
      end
    end
    if (na && rx_end) begin nv = 1; nacc = 0; na = 0; end
    if (cfg_we) m_regs[cfg_addr] = cfg_wdata;
    @(posedge clk);
    #1;
    m_act = na; m_got = ng; m_hiok = nh; m_vld = nv; m_acc = nacc;
    check(tag, res_vld, m_vld, "res_vld");
    if (m_vld) check(tag, res_accept, m_acc, "res_accept");
    check("R2", cfg_rdata, m_regs[cfg_addr], "cfg_rdata");
  endtask

  task automatic idle();
    rx_start = 0; rx_byte_vld = 0; rx_end = 0; cfg_we = 0;
    tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic frame1(input logic [7:0] b);
    rx_start = 1; tick(); rx_start = 0;
    rx_byte_vld = 1; rx_byte = b; tick(); rx_byte_vld = 0;
    idle();
  endtask

  task automatic frame2(input logic [7:0] h, input logic [7:0] l);
    rx_start = 1; rx_byte_vld = 1; rx_byte = h; tick(); rx_start = 0;
    rx_byte = l; tick(); rx_byte_vld = 0;
    idle();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_regs[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset contents
    tag = "R1";
    for (int i = 0; i < 4; i++) begin
      cfg_addr = 2'(i);
      #1 check("R1", cfg_rdata, 0, "reset reg");
    end
    check("R1", res_vld, 0, "reset res_vld");
    idle();
    // R10: strobes before first start
    tag = "R10";
    rx_byte_vld = 1; rx_byte = 8'h00; rx_end = 1; tick(); idle();
    // R2: write and read back
    tag = "R2";
    wr(0, 8'h31); wr(1, 8'h52); wr(2, 8'hA5); wr(3, 8'h3C);
    for (int i = 0; i < 4; i++) begin cfg_addr = 2'(i); idle(); end
    // R3 / R6: one-octet list mode
    tag = "R3";
    two_byte = 0; mask_lo = 0;
    frame1(8'hA5); frame1(8'h3C); frame1(8'hA4);
    tag = "R6";
    frame1(8'h31); frame1(8'h52);
    // R5: low group
    tag = "R5";
    frame1(8'hFF); frame1(8'hFC);
    // R4: low mask mode, secondary 0F ignores low nibble
    tag = "R4";
    mask_lo = 1; wr(3, 8'h0F);
    frame1(8'hA0); frame1(8'hAF); frame1(8'hB5); frame1(8'h0F);
    // R7: two-octet mode
    tag = "R7";
    two_byte = 1; mask_lo = 0; mask_hi = 0; wr(3, 8'h3C);
    frame2(8'h31, 8'hA5); frame2(8'h52, 8'h3C); frame2(8'h30, 8'hA5); frame2(8'h31, 8'h00);
    // R5: high group FC/FE, not FD
    tag = "R5";
    frame2(8'hFC, 8'hA5); frame2(8'hFE, 8'hFF); frame2(8'hFD, 8'hA5);
    // R4: high mask mode
    tag = "R4";
    mask_hi = 1; wr(1, 8'hF0);
    frame2(8'hC1, 8'hA5); frame2(8'h32, 8'hA5);
    mask_hi = 0;
    // R8: result held across idle cycles
    tag = "R8";
    frame2(8'h31, 8'hA5); idle(); idle();
    check("R8", res_accept, 1, "held accept");
    // R9: end before final octet
    tag = "R9";
    rx_start = 1; tick(); rx_start = 0; rx_end = 1; tick(); rx_end = 0; idle();
    rx_start = 1; rx_byte_vld = 1; rx_byte = 8'h31; rx_end = 1; tick();
    rx_start = 0; rx_byte_vld = 0; rx_end = 0; idle();
    // R10: strobes after result ignored
    tag = "R10";
    frame2(8'h31, 8'hA5);
    rx_byte_vld = 1; rx_byte = 8'h00; tick(); rx_byte = 8'h31; tick();
    rx_byte_vld = 0; rx_end = 1; tick(); rx_end = 0; idle();
    check("R10", res_accept, 1, "accept untouched");
    // R11: write collides with the octet using that register
    tag = "R11";
    two_byte = 0;
    rx_start = 1; tick(); rx_start = 0;
    rx_byte_vld = 1; rx_byte = 8'hA5; cfg_we = 1; cfg_addr = 2; cfg_wdata = 8'h77; tick();
    rx_byte_vld = 0; cfg_we = 0; idle();
    frame1(8'hA5); frame1(8'h77);
    // R12: end with final octet, start with end
    tag = "R12";
    rx_start = 1; tick(); rx_start = 0;
    rx_byte_vld = 1; rx_byte = 8'h77; rx_end = 1; tick();
    rx_byte_vld = 0; rx_end = 0; idle();
    rx_start = 1; rx_byte_vld = 1; rx_byte = 8'h77; tick();
    rx_start = 0; rx_byte_vld = 0; idle();
    rx_start = 1; rx_end = 1; tick(); rx_start = 0; rx_end = 0; idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule